// File: doc/BRIEF.md
# Configuration Integrity Mismatch Monitor

The block keeps a bank of configuration words together with a shadow bank in which each word is stored as its bitwise complement. While the configuration is live, every word is compared against its shadow on every cycle. A pair whose XOR is not all ones marks the bank as corrupted. The block then raises a registered reset request for a fixed number of cycles. Once that window ends, it reloads both banks from a non-volatile image through a simple request/valid load port.

An active-low sticky flag records that a corruption-triggered reset has taken place. Only this event drives the flag low. Other hard reset sources trigger a reload but leave the flag alone. Software returns the flag high by writing a one, and power-on reset also returns it high. While a load is in progress the comparison is masked, so a half-written bank cannot raise a false reset. The `upset_cfg` and `upset_shd` inputs flip stored bits and model random corruption of either bank.

Top module: `cim_monitor`

## Requirements
- R1: While `por_n` is low, `mm_flag_n` is 1, `rst_req` is 0, `cfg_valid` is 0, `img_req` is 1 and `img_addr` is 0.
- R2: During a load, each cycle with `img_vld` high writes `img_cfg` into the configuration bank and `img_shd` into the shadow bank, both at index `img_addr`, and then advances `img_addr` by one. The write that stores index N-1 makes `cfg_valid` go high on the next cycle. `cfg_out` then holds word i at bits [i*W +: W].
- R3: While `cfg_valid` is high, if any pair has `cfg[i] ^ shd[i]` other than all ones, `rst_req` goes high on the following clock edge.
- R4: `rst_req` stays high for exactly HOLD_CYC cycles. In the cycle it falls, a new load starts: `img_req` is 1, `img_addr` is 0 and `cfg_valid` is 0.
- R5: `mm_flag_n` goes to 0 on the same edge on which `rst_req` rises. It stays 0 through the reload and afterwards.
- R6: A one-cycle `ext_rst` while `cfg_valid` is high (with no mismatch) restarts the load from index 0 on the next edge. It does not raise `rst_req` and does not change `mm_flag_n`. A one-cycle `ext_rst` during a load sends `img_addr` back to 0.
- R7: While a load is in progress, including cycles where the loader stalls with `img_vld` low, corrupted pairs do not raise `rst_req`.
- R8: A cycle with `flag_w1` high sets `mm_flag_n` to 1 on the next edge. If a mismatch reset begins on that same edge, the flag goes to 0 instead.
- R9: Flipping the same bit in both the configuration word and its shadow keeps the complement relation. This causes no reset, and `cfg_out` shows the flipped bit.
- R10: `ext_rst` is ignored while `rst_req` is high: the hold window keeps its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst | input | 1 | Synchronous hard reset from other sources; forces a reload |
| flag_w1 | input | 1 | Write-one strobe that sets `mm_flag_n` back to 1 |
| img_vld | input | 1 | Load port: image word present for `img_addr` |
| img_cfg | input | W | Load port: configuration word from the image |
| img_shd | input | W | Load port: shadow (complement) word from the image |
| upset_cfg | input | N*W | Bit flips applied to the configuration bank (corruption model) |
| upset_shd | input | N*W | Bit flips applied to the shadow bank (corruption model) |
| img_req | output | 1 | Load port: the block is loading and wants word `img_addr` |
| img_addr | output | AW | Load port: index of the word being loaded |
| cfg_out | output | N*W | Current configuration bank contents |
| cfg_valid | output | 1 | Banks fully loaded; comparison armed |
| rst_req | output | 1 | Registered reset request on mismatch |
| mm_flag_n | output | 1 | Sticky mismatch flag, active low |

## Verification
The main function is tried by sweeping every bit of every word with three upset patterns: a flip in the configuration bank alone, a flip in the shadow bank alone, and the same flip in both. The single-bank flips show that a difference in any bit position of any register is detected. The paired flip shows that the check tests the complement relation and not equality with the loaded image. Further sequences separate the causes that change the flag or start a reload. These are: a write-one that collides with a mismatch, external resets during run, during load and during the hold window, and corruption injected while the loader is stalled.

// File: rtl/cim_pkg.sv
package cim_pkg;
   typedef enum logic [1:0] {
      CIM_LOAD = 2'd0,
      CIM_RUN  = 2'd1,
      CIM_HOLD = 2'd2
   } cim_state_e;
endpackage

// File: rtl/cim_bank.sv
module cim_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_cfg,
   input  logic [W-1:0] wr_shd,
   input  logic [W-1:0] hit_cfg,
   input  logic [W-1:0] hit_shd,
   output logic [W-1:0] cfg_q,
   output logic         pair_bad
);
   logic [W-1:0] shd_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg_q <= '0;
         shd_q <= '1;
      end else if (wr_en) begin
         cfg_q <= wr_cfg;
         shd_q <= wr_shd;
      end else begin
         cfg_q <= cfg_q ^ hit_cfg;
         shd_q <= shd_q ^ hit_shd;
      end
   end

   assign pair_bad = ((cfg_q ^ shd_q) != {W{1'b1}});

   // R9: equal flips in both halves leave the pair verdict unchanged
   a_r9_equal_flip_keeps_pair : assert property (@(posedge clk) disable iff (!por_n)
      (!wr_en && (hit_cfg == hit_shd)) |=> (pair_bad == $past(pair_bad)));
endmodule

// File: rtl/cim_flag.sv
module cim_flag (
   input  logic clk,
   input  logic por_n,
   input  logic set_evt,
   input  logic w1_clr,
   output logic flag_n
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       flag_n <= 1'b1;
      else if (set_evt) flag_n <= 1'b0;
      else if (w1_clr)  flag_n <= 1'b1;
   end

   // R8: a mismatch event wins over a write-one in the same cycle
   a_r8_event_priority : assert property (@(posedge clk) disable iff (!por_n)
      set_evt |=> !flag_n);
endmodule

// File: rtl/cim_seq.sv
module cim_seq
   import cim_pkg::*;
#(
   parameter int N        = 4,
   parameter int HOLD_CYC = 4,
   parameter int AW       = 2
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          ext_rst,
   input  logic          img_vld,
   input  logic          any_bad,
   output logic          img_req,
   output logic [AW-1:0] img_addr,
   output logic          load_we,
   output logic          cfg_valid,
   output logic          rst_req,
   output logic          mm_event
);
   localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [AW-1:0] LAST  = AW'(N - 1);
   localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

   cim_state_e    st_q;
   logic [AW-1:0] addr_q;
   logic [HW-1:0] hcnt_q;
   logic          rst_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q   <= CIM_LOAD;
         addr_q <= '0;
         hcnt_q <= '0;
         rst_q  <= 1'b0;
      end else begin
         case (st_q)
            CIM_LOAD: begin
               if (ext_rst) begin
                  addr_q <= '0;
               end else if (img_vld) begin
                  if (addr_q == LAST) begin
                     addr_q <= '0;
                     st_q   <= CIM_RUN;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                  end
               end
            end
            CIM_RUN: begin
               if (any_bad) begin
                  st_q   <= CIM_HOLD;
                  hcnt_q <= '0;
                  rst_q  <= 1'b1;
               end else if (ext_rst) begin
                  st_q   <= CIM_LOAD;
                  addr_q <= '0;
               end
            end
            CIM_HOLD: begin
               if (hcnt_q == HLAST) begin
                  st_q   <= CIM_LOAD;
                  addr_q <= '0;
                  rst_q  <= 1'b0;
               end else begin
                  hcnt_q <= hcnt_q + 1'b1;
               end
            end
            default: st_q <= CIM_LOAD;
         endcase
      end
   end

   assign img_req   = (st_q == CIM_LOAD);
   assign img_addr  = addr_q;
   assign load_we   = (st_q == CIM_LOAD) && img_vld && !ext_rst;
   assign cfg_valid = (st_q == CIM_RUN);
   assign rst_req   = rst_q;
   assign mm_event  = (st_q == CIM_RUN) && any_bad;

   // R3: a live mismatch raises the request on the next edge
   a_r3_req_after_mismatch : assert property (@(posedge clk) disable iff (!por_n)
      (cfg_valid && any_bad) |=> rst_req);
   // R4: the request is not dropped before the hold window is used up
   a_r4_hold_kept : assert property (@(posedge clk) disable iff (!por_n)
      (rst_q && hcnt_q != HLAST) |=> rst_q);
   // R4: the request ends into a fresh load from index 0
   a_r4_end_into_load : assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_req) |-> (img_req && addr_q == '0 && !cfg_valid));
   // R2: the load index never leaves the bank
   a_r2_addr_in_range : assert property (@(posedge clk) disable iff (!por_n)
      img_req |-> (addr_q <= LAST));
endmodule

// File: rtl/cim_monitor.sv
module cim_monitor
   import cim_pkg::*;
#(
   parameter int N        = 4,
   parameter int W        = 8,
   parameter int HOLD_CYC = 4,
   localparam int AW      = (N > 1) ? $clog2(N) : 1
) (
   input  logic           clk,
   input  logic           por_n,
   input  logic           ext_rst,
   input  logic           flag_w1,
   input  logic           img_vld,
   input  logic [W-1:0]   img_cfg,
   input  logic [W-1:0]   img_shd,
   input  logic [N*W-1:0] upset_cfg,
   input  logic [N*W-1:0] upset_shd,
   output logic           img_req,
   output logic [AW-1:0]  img_addr,
   output logic [N*W-1:0] cfg_out,
   output logic           cfg_valid,
   output logic           rst_req,
   output logic           mm_flag_n
);
   if (N < 1) begin : g_bad_n
      $error("cim_monitor: N must be at least 1");
   end
   if (W < 1) begin : g_bad_w
      $error("cim_monitor: W must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("cim_monitor: HOLD_CYC must be at least 1");
   end

   logic         load_we;
   logic         mm_event;
   logic [N-1:0] bad_vec;
   logic         any_bad;

   cim_seq #(.N(N), .HOLD_CYC(HOLD_CYC), .AW(AW)) u_seq (
      .clk       (clk),
      .por_n     (por_n),
      .ext_rst   (ext_rst),
      .img_vld   (img_vld),
      .any_bad   (any_bad),
      .img_req   (img_req),
      .img_addr  (img_addr),
      .load_we   (load_we),
      .cfg_valid (cfg_valid),
      .rst_req   (rst_req),
      .mm_event  (mm_event)
   );

   for (genvar i = 0; i < N; i++) begin : g_pair
      logic wr_sel;
      assign wr_sel = load_we && (img_addr == AW'(i));
      cim_bank #(.W(W)) u_bank (
         .clk      (clk),
         .por_n    (por_n),
         .wr_en    (wr_sel),
         .wr_cfg   (img_cfg),
         .wr_shd   (img_shd),
         .hit_cfg  (upset_cfg[i*W +: W]),
         .hit_shd  (upset_shd[i*W +: W]),
         .cfg_q    (cfg_out[i*W +: W]),
         .pair_bad (bad_vec[i])
      );
   end

   assign any_bad = |bad_vec;

   cim_flag u_flag (
      .clk     (clk),
      .por_n   (por_n),
      .set_evt (mm_event),
      .w1_clr  (flag_w1),
      .flag_n  (mm_flag_n)
   );

   // R5: the flag only falls together with a new reset request
   a_r5_flag_falls_with_req : assert property (@(posedge clk) disable iff (!por_n)
      $fell(mm_flag_n) |-> $rose(rst_req));
   // R8: the flag only rises after a write-one strobe
   a_r8_flag_rise_needs_w1 : assert property (@(posedge clk) disable iff (!por_n)
      $rose(mm_flag_n) |-> $past(flag_w1));
   // R7: a request can only start from the armed state
   a_r7_masked_in_load : assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req) |-> $past(cfg_valid));
   // R6: a clean external reset in run restarts the load without a request
   a_r6_ext_reload : assert property (@(posedge clk) disable iff (!por_n)
      (ext_rst && cfg_valid && !any_bad) |=> (img_req && img_addr == '0 && !rst_req
                                             && $stable(mm_flag_n)));
endmodule

// File: tb/sim_cim_monitor.sv
module sim_cim_monitor;
   localparam int N  = 4;
   localparam int W  = 4;
   localparam int H  = 3;
   localparam int AW = 2;

   logic           clk = 1'b0;
   logic           por_n = 1'b0;
   logic           ext_rst = 1'b0;
   logic           flag_w1 = 1'b0;
   logic           stall = 1'b0;
   logic           img_vld;
   logic [W-1:0]   img_cfg, img_shd;
   logic [N*W-1:0] upset_cfg = '0, upset_shd = '0;
   logic           img_req;
   logic [AW-1:0]  img_addr;
   logic [N*W-1:0] cfg_out;
   logic           cfg_valid, rst_req, mm_flag_n;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;
   logic [N*W-1:0] cur;

   always #4 clk = ~clk;

   function automatic logic [W-1:0] img_c(input int i);
      return W'(i * 5 + 3);
   endfunction

   function automatic logic [N*W-1:0] img_all();
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = img_c(i);
      return v;
   endfunction

   // image store model: answers every request unless stalled
   assign img_vld = img_req && !stall;
   assign img_cfg = img_c(int'(img_addr));
   assign img_shd = ~img_c(int'(img_addr));

   cim_monitor #(.N(N), .W(W), .HOLD_CYC(H)) u0 (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .flag_w1(flag_w1),
      .img_vld(img_vld), .img_cfg(img_cfg), .img_shd(img_shd),
      .upset_cfg(upset_cfg), .upset_shd(upset_shd),
      .img_req(img_req), .img_addr(img_addr), .cfg_out(cfg_out),
      .cfg_valid(cfg_valid), .rst_req(rst_req), .mm_flag_n(mm_flag_n)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_valid();
      int n = 0;
      while (!cfg_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk("R2 reload completes", cfg_valid, 1);
   endtask

   task automatic pulse_w1();
      @(negedge clk); flag_w1 = 1'b1;
      @(negedge clk); flag_w1 = 1'b0;
      chk("R8 write-one sets flag", mm_flag_n, 1);
   endtask

   // mode 0: configuration bank, 1: shadow bank, 2: both banks
   task automatic hit(input int i, input int b, input int mode);
      @(negedge clk);
      if (mode != 1) upset_cfg[i*W + b] = 1'b1;
      if (mode != 0) upset_shd[i*W + b] = 1'b1;
      @(negedge clk);
      upset_cfg = '0;
      upset_shd = '0;
      chk("R3 no request before next edge", rst_req, 0);
      if (mode == 2) begin
         cur[i*W + b] = ~cur[i*W + b];
         repeat (4) @(negedge clk);
         chk("R9 paired flip causes no reset", rst_req, 0);
         chk("R9 paired flip visible", cfg_out, cur);
      end else begin
         @(negedge clk);
         chk("R3 mismatch raises request", rst_req, 1);
         chk("R5 flag low with request", mm_flag_n, 0);
         repeat (H - 1) @(negedge clk);
         chk("R4 request held", rst_req, 1);
         @(negedge clk);
         chk("R4 request released", rst_req, 0);
         chk("R4 reload starts", {img_req, 2'(img_addr), cfg_valid}, {1'b1, 2'd0, 1'b0});
         wait_valid();
         cur = img_all();
         chk("R2 reload restores image", cfg_out, cur);
         chk("R5 flag stays low", mm_flag_n, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 flag", mm_flag_n, 1);
      chk("R1 rst_req", rst_req, 0);
      chk("R1 cfg_valid", cfg_valid, 0);
      chk("R1 load request", {img_req, 2'(img_addr)}, {1'b1, 2'd0});
      por_n = 1'b1;
      // R2: one word per cycle, valid after the last
      for (int k = 1; k < N; k++) begin
         @(negedge clk);
         chk("R2 load index advances", img_addr, k);
         chk("R2 not valid mid-load", cfg_valid, 0);
      end
      @(negedge clk);
      chk("R2 valid after last word", cfg_valid, 1);
      cur = img_all();
      chk("R2 image loaded", cfg_out, cur);

      // R3/R9 sweep over every bit of every word
      for (int i = 0; i < N; i++) begin
         for (int b = 0; b < W; b++) begin
            hit(i, b, 2);
            hit(i, b, 0);
            pulse_w1();
            hit(i, b, 1);
            pulse_w1();
         end
      end

      // R8 collision and R10 external reset during hold
      hit(0, 0, 0);
      @(negedge clk);
      upset_cfg[W + 2] = 1'b1;
      @(negedge clk);
      upset_cfg = '0;
      flag_w1 = 1'b1;
      @(negedge clk);
      flag_w1 = 1'b0;
      chk("R8 mismatch beats write-one", mm_flag_n, 0);
      chk("R3 request raised", rst_req, 1);
      ext_rst = 1'b1;
      @(negedge clk);
      ext_rst = 1'b0;
      chk("R10 hold kept under ext_rst", rst_req, 1);
      @(negedge clk);
      chk("R10 hold kept", rst_req, 1);
      @(negedge clk);
      chk("R10 hold ends on time", rst_req, 0);
      wait_valid();
      pulse_w1();

      // R6 external reset in run, flag high then low
      @(negedge clk); ext_rst = 1'b1;
      @(negedge clk); ext_rst = 0;
      chk("R6 restart load", {img_req, 2'(img_addr), cfg_valid, rst_req}, {1'b1, 2'd0, 1'b0, 1'b0});
      chk("R6 flag unchanged high", mm_flag_n, 1);
      wait_valid();
      chk("R6 image after ext reload", cfg_out, img_all());
      hit(2, 1, 1);
      @(negedge clk); ext_rst = 1'b1;
      @(negedge clk); ext_rst = 1'b0;
      chk("R6 flag unchanged low", mm_flag_n, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R6 load progressed", img_addr, 2);
      stall = 1'b1;
      @(negedge clk);
      chk("R6 stalled index held", img_addr, 2);
      ext_rst = 1'b1;
      @(negedge clk);
      ext_rst = 1'b0;
      chk("R6 ext_rst in load rewinds index", img_addr, 0);

      // R7 corruption while loading is masked
      @(negedge clk);
      upset_cfg[(N-1)*W + 1] = 1'b1;
      upset_shd[0] = 1'b1;
      @(negedge clk);
      upset_cfg = '0;
      upset_shd = '0;
      begin
         bit seen = 1'b0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
         end
         chk("R7 no request during stalled load", seen, 0);
      end
      stall = 1'b0;
      wait_valid();
      repeat (3) @(negedge clk);
      chk("R7 clean after reload", rst_req, 0);
      chk("R7 image restored", cfg_out, img_all());

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end
endmodule